// File: doc/BRIEF.md
# Zero-Terminated String Display Sequencer

This block copies a byte string from memory to a character display over an 8-bit parallel data port and a single strobe line. A one-cycle start request hands it the address of the first byte. From there it reads the memory one byte at a time through a synchronous read port with one cycle of latency. Each byte is sent to the display in three timed phases:

- the strobe is raised;
- the byte is placed on the data port;
- the strobe is dropped.

Each phase is held for a programmable number of clock cycles, which must cover the display's minimum timing. A zero byte marks the end of the string. It is never sent, and reading it ends the transfer with a one-cycle completion pulse.

The display must already be initialised before the first start request. The sequencer does not poll the display for readiness; it relies only on the fixed phase length. While a transfer is in progress, the busy output is high and further start requests are dropped.

Top module: `lcd_str_seq`

## Requirements
- R1: Start in idle. When `start_i` is high in an idle cycle, the block captures `start_addr_i`. In the next cycle it raises `mem_rd_o` for exactly one cycle with `mem_addr_o` equal to that address. `mem_rd_o` is only ever high while `busy_o` is high.
- R2: Strobe rise. For a nonzero byte, `lcd_strobe_o` rises in the cycle after the read data returns. It stays high for `DELAY` cycles while the data port still shows the previous value.
- R3: Data presentation. After those `DELAY` cycles, `lcd_data_o` takes the new byte and holds it. The strobe stays high for another `DELAY` cycles. The data port never changes while the strobe is low.
- R4: Strobe fall. `lcd_strobe_o` then falls and stays low for `DELAY` cycles. The next read is issued in the cycle after those `DELAY` cycles end.
- R5: Zero byte. A zero byte is never presented: it raises no strobe and leaves `lcd_data_o` unchanged.
- R6: Completion. `done_o` is high for exactly one cycle, the cycle after the zero byte returns. `busy_o` is low in that same cycle.
- R7: Address step. The read address increases by one for each byte sent, wrapping modulo 2^`AW`.
- R8: Start while busy. A start request while `busy_o` is high has no effect on timing, addresses or outputs.
- R9: Reset. After reset, `busy_o`, `done_o`, `mem_rd_o`, `lcd_strobe_o` and `lcd_data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| start_addr_i | input | AW | Address of the first string byte |
| mem_rd_o | output | 1 | Memory read enable |
| mem_addr_o | output | AW | Memory read address |
| mem_data_i | input | 8 | Read data, valid one cycle after `mem_rd_o` |
| lcd_data_o | output | 8 | Display data port |
| lcd_strobe_o | output | 1 | Display strobe |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at end of string |

## Verification
The following are checked on every cycle:
- the strobe moves only at a phase boundary or right after nonzero read data;
- the data port moves only while the strobe is high;
- no strobe rises on a zero byte;
- the completion pulse lasts one cycle and never overlaps busy;
- the pointer moves only by a load or a single step;
- the shared counter never wraps below zero.

The exact phase lengths and the link between each read address and the byte it returns are shown only by the bench scenarios. The same holds for the dropped start request and for address wrap-around. In those scenarios a behavioural model predicts every output on every cycle.

// File: rtl/lcd_str_pkg.sv
// Shared types for the string display sequencer.
package lcd_str_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start request
        ST_FETCH,  // read issued to memory
        ST_CHECK,  // read data valid, tested for zero
        ST_HI,     // strobe high, old data still shown
        ST_DATA,   // strobe high, new byte shown
        ST_LO      // strobe low, byte held
    } seq_state_t;
endpackage

// File: rtl/lcd_str_delay.sv
// Phase timer: one down-counter shared by all three strobe phases.
// Assumes DELAY >= 2. A load makes expired_o rise after DELAY cycles.
module lcd_str_delay #(
    parameter int DELAY = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int CW = (DELAY > 2) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] LOADV = CW'(DELAY - 1);

    logic [CW-1:0] cnt_q;

    // Count down from the load value and park at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= LOADV;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/lcd_str_ptr.sv
// Read pointer: loaded at start, stepped by one after each byte sent.
// Assumes load and step never coincide; wraps modulo 2^AW.
module lcd_str_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          step_i,
    output logic [AW-1:0] ptr_o
);
    logic [AW-1:0] ptr_q;

    // Hold, load or advance the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (load_i)
            ptr_q <= load_val_i;
        else if (step_i)
            ptr_q <= ptr_q + 1'b1;
    end

    assign ptr_o = ptr_q;

    AST_PTR_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ptr_q) && !$past(load_i)) |-> (ptr_q == $past(ptr_q) + 1'b1)); // R7
endmodule

// File: rtl/lcd_str_ctrl.sv
// Sequencer control: fetch, zero test and three timed strobe phases.
// Assumes memory data is valid one cycle after the read request.
module lcd_str_ctrl
    import lcd_str_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] rdata_i,
    input  logic          expired_i,
    output logic          delay_load_o,
    output logic          ptr_load_o,
    output logic          ptr_step_o,
    output logic          mem_rd_o,
    output logic          strobe_o,
    output logic [DW-1:0] data_o,
    output logic          busy_o,
    output logic          done_o
);
    seq_state_t    state_q, state_d;
    logic [DW-1:0] char_q;
    logic [DW-1:0] data_q;
    logic          strobe_q;
    logic          done_q;
    logic          is_nul;

    assign is_nul = (rdata_i == '0);

    // Next-state choice; phases end when the shared timer expires.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_CHECK;
            ST_CHECK: state_d = is_nul ? ST_IDLE : ST_HI;
            ST_HI:    if (expired_i) state_d = ST_DATA;
            ST_DATA:  if (expired_i) state_d = ST_LO;
            ST_LO:    if (expired_i) state_d = ST_FETCH;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Control strobes toward the timer and the pointer.
    always_comb begin
        delay_load_o = ((state_q == ST_CHECK) && !is_nul)
                    || ((state_q == ST_HI)   && expired_i)
                    || ((state_q == ST_DATA) && expired_i);
        ptr_load_o   = (state_q == ST_IDLE) && start_i;
        ptr_step_o   = (state_q == ST_LO) && expired_i;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the returned byte once it has been tested.
    always_ff @(posedge clk) begin
        if (!rst_n)                             char_q <= '0;
        else if (state_q == ST_CHECK && !is_nul) char_q <= rdata_i;
    end

    // Registered display outputs and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            data_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= (state_q == ST_CHECK) && is_nul;
            if (state_q == ST_CHECK && !is_nul) strobe_q <= 1'b1;
            if (state_q == ST_HI && expired_i)  data_q   <= char_q;
            if (state_q == ST_DATA && expired_i) strobe_q <= 1'b0;
        end
    end

    assign mem_rd_o = (state_q == ST_FETCH);
    assign strobe_o = strobe_q;
    assign data_o   = data_q;
    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = done_q;

    AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> busy_o); // R1
    AST_STROBE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(strobe_q) |-> ($past(expired_i) || $past(state_q == ST_CHECK))); // R2
    AST_DATA_UNDER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_q) |-> strobe_q); // R3
    AST_NO_NUL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_q) |-> ($past(rdata_i) != '0)); // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R6
endmodule

// File: rtl/lcd_str_seq.sv
// Top: sends a zero-terminated byte string from memory to a display.
// Assumes the display is initialised and the memory has one cycle of read latency.
module lcd_str_seq #(
    parameter int AW    = 16,
    parameter int DELAY = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    output logic          mem_rd_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic [7:0]    mem_data_i,
    output logic [7:0]    lcd_data_o,
    output logic          lcd_strobe_o,
    output logic          busy_o,
    output logic          done_o
);
    localparam int DW = 8;

    logic delay_load, expired, ptr_load, ptr_step;

    lcd_str_delay #(.DELAY(DELAY)) u_delay (
        .clk(clk), .rst_n(rst_n), .load_i(delay_load), .expired_o(expired)
    );

    lcd_str_ptr #(.AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load_i(ptr_load), .load_val_i(start_addr_i),
        .step_i(ptr_step), .ptr_o(mem_addr_o)
    );

    lcd_str_ctrl #(.DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rdata_i(mem_data_i),
        .expired_i(expired), .delay_load_o(delay_load), .ptr_load_o(ptr_load),
        .ptr_step_o(ptr_step), .mem_rd_o(mem_rd_o), .strobe_o(lcd_strobe_o),
        .data_o(lcd_data_o), .busy_o(busy_o), .done_o(done_o)
    );
endmodule

// File: tb/tb_lcd_str_seq.sv
module tb_lcd_str_seq;
    localparam int AW = 8;
    localparam int D  = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic mem_rd;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_data = 8'h00;
    logic [7:0] lcd_data;
    logic strobe, busy, done;

    logic [7:0] mem [256];
    int checks = 0;
    int failures = 0;
    logic [7:0] last_dat = 8'h00;

    // expected word: {rd, busy, done, strobe, data[7:0], addr[7:0]}
    logic [19:0] expq [$];

    always #2 clk = ~clk;

    lcd_str_seq #(.AW(AW), .DELAY(D)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
        .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_data),
        .lcd_data_o(lcd_data), .lcd_strobe_o(strobe), .busy_o(busy), .done_o(done)
    );

    // one-cycle-latency memory model
    always @(posedge clk) if (mem_rd) mem_data <= mem[mem_addr];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] pk(bit rd, bit bz, bit dn, bit st, logic [7:0] d, logic [7:0] a);
        return {rd, bz, dn, st, d, a};
    endfunction

    // behavioural prediction of every cycle after the start edge
    task automatic predict(input logic [7:0] a);
        logic [7:0] p = a;
        logic [7:0] c;
        expq.delete();
        forever begin
            expq.push_back(pk(1, 1, 0, 0, last_dat, p));
            expq.push_back(pk(0, 1, 0, 0, last_dat, 0));
            c = mem[p];
            if (c == 8'h00) begin
                expq.push_back(pk(0, 0, 1, 0, last_dat, 0));
                expq.push_back(pk(0, 0, 0, 0, last_dat, 0));
                break;
            end
            for (int i = 0; i < D; i++) expq.push_back(pk(0, 1, 0, 1, last_dat, 0));
            for (int i = 0; i < D; i++) expq.push_back(pk(0, 1, 0, 1, c, 0));
            for (int i = 0; i < D; i++) expq.push_back(pk(0, 1, 0, 0, c, 0));
            last_dat = c;
            p = p + 8'd1;
        end
    endtask

    // start a transfer and compare outputs against the model every cycle
    task automatic run(input logic [7:0] a, input int ign_at, input string nm);
        logic [19:0] e;
        predict(a);
        @(negedge clk);
        start = 1'b1; start_addr = a;
        @(negedge clk);
        start = 1'b0; start_addr = 8'hAA;
        for (int k = 0; expq.size() > 0; k++) begin
            e = expq.pop_front();
            chk(mem_rd == e[19], {nm, " R1 mem_rd"}, mem_rd, e[19]);
            if (e[19]) chk(mem_addr == e[7:0], {nm, " R7 mem_addr"}, mem_addr, e[7:0]);
            chk(busy == e[18], {nm, " R8 busy"}, busy, e[18]);
            chk(done == e[17], {nm, " R6 done"}, done, e[17]);
            chk(strobe == e[16], {nm, " R2/R4 strobe"}, strobe, e[16]);
            chk(lcd_data == e[15:8], {nm, " R3/R5 data"}, lcd_data, e[15:8]);
            if (k == ign_at) begin
                start = 1'b1; start_addr = 8'h55;   // R8: request while busy
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[8'h10] = 8'h48; mem[8'h11] = 8'h69;              // two bytes
        mem[8'h30] = 8'hFF;                                    // single byte
        mem[8'hFE] = 8'h5A; mem[8'hFF] = 8'hA5;               // wraps to 0x00 = zero
        mem[8'h40] = 8'h31; mem[8'h41] = 8'h32; mem[8'h42] = 8'h33;
        mem[8'h55] = 8'h77; mem[8'h56] = 8'h78;               // must never be read
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk(busy == 1'b0, "R9 busy", busy, 0);
        chk(done == 1'b0, "R9 done", done, 0);
        chk(mem_rd == 1'b0, "R9 mem_rd", mem_rd, 0);
        chk(strobe == 1'b0, "R9 strobe", strobe, 0);
        chk(lcd_data == 8'h00, "R9 data", lcd_data, 0);
        rst_n = 1'b1;
        run(8'h10, -1, "two-byte");
        run(8'h20, -1, "empty R5");
        run(8'h30, -1, "single R2");
        run(8'hFE, -1, "wrap R7");
        run(8'h40, 5, "ignore-start R8");
        run(8'h40, 2 + D + 3, "ignore-mid R8");
        // R5: zero byte left the data port unchanged after the last run
        chk(lcd_data == 8'h33, "R5 final data", lcd_data, 8'h33);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule